// File: doc/BRIEF.md
# Batched Register Access Command Engine

This block sits on the controller side of a command mailbox. It executes one register-access command at a time against a byte-wide local register file with 16-bit addresses. A command arrives as a command code, a 4-bit sub-command, a byte count and a packed payload. The sub-command selects one of three operations. A batch of one to five byte reads returns its results in a small read buffer. A batch of one to five byte writes carries its addresses first and its data bytes after them. A single masked read-modify-write changes only the selected bits of one register.

The engine checks the code, the sub-command and the byte count when the start pulse is taken. It then makes one register access per clock cycle, in ascending item order, and pulses `doneOut` with `errOut` valid alongside it. If the command is malformed, the engine finishes at once with the error flag set. In that case it touches neither the register file nor the read buffer. A start pulse that arrives while a command is in progress is dropped.

Top module: `regBatchEngine`

## Requirements
- R1: A command is accepted only when the code is 0xFF and the sub-command is 0 (write), 1 (read) or 2 (read-modify-write). Any other code or sub-command finishes with `errOut`=1 and makes no register access.
- R2: A read of N items (1 ≤ N ≤ 5) has a byte count of 2N. Item k uses payload byte 2k as the address low byte and byte 2k+1 as the high byte. Payload byte b sits at `payloadIn[8b+7:8b]`. The engine issues one `rfRdEn` access per item.
- R3: The value read for item k is stored at `rdBufOut[8k+7:8k]`. An accepted read first zeroes the whole buffer, so bytes at N and above read 0. Only an accepted read changes the buffer.
- R4: A write of N items (1 ≤ N ≤ 5) has a byte count of 3N. Item k writes payload byte 2N+k to the address held in bytes 2k and 2k+1.
- R5: Items are executed in ascending order, one per cycle. When an address repeats within a write batch, the register ends up holding the byte of the highest-numbered item.
- R6: A read-modify-write has a byte count of exactly 4. Bytes 0 and 1 hold the address (low byte first), byte 2 the value and byte 3 the mask. The engine reads the register in one cycle and writes (old & ~mask) | (value & mask) to the same address in the next cycle.
- R7: A byte count outside the set allowed for an accepted sub-command finishes with `errOut`=1. It leaves the register file and `rdBufOut` unchanged.
- R8: The first access is presented in the cycle after the start is taken. `doneOut` is high for the cycle after the last access, and an error finishes in the cycle after the start. `errOut` is valid while `doneOut` is high, and `busy` is low at that point.
- R9: `startIn` is ignored while `busy` is high, and the command in progress runs on unchanged.
- R10: `rfRdEn` and `rfWrEn` are never high together, and neither is high while `busy` is low.
- R11: After reset, `busy`, `doneOut`, `errOut`, `rfRdEn`, `rfWrEn` and `rdBufOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request, sampled while idle |
| cmdCodeIn | input | 8 | Command code |
| subCmdIn | input | 4 | Sub-command: 0 write, 1 read, 2 read-modify-write |
| sizeIn | input | 8 | Payload byte count |
| payloadIn | input | 120 | Packed payload, byte b at bits 8b+7:8b |
| rfAddr | output | 16 | Register file address |
| rfRdEn | output | 1 | Register file read strobe |
| rfRdData | input | 8 | Register file read data for `rfAddr`, same cycle |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrData | output | 8 | Register file write data |
| busy | output | 1 | Command in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| errOut | output | 1 | Error status of the last completed command |
| rdBufOut | output | 40 | Read buffer, item k at bits 8k+7:8k |

## Verification
The assertions rely on three properties of the environment. The register file must return the byte for the presented address combinationally in the same cycle. The payload and command fields must be valid in the cycle `startIn` is taken. Reset must be held for at least one edge before the first command. The bench models the register file as a byte array answered through a continuous assignment. It drives every command field at the falling edge together with `startIn`, and it drops `startIn` one cycle later. During a command it changes `startIn` only in the deliberate collision test, and it keeps `payloadIn` steady otherwise.

// File: rtl/regBatchPkg.sv
package regBatchPkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int SUB_W  = 4;
  // Item counter width; covers batches of up to 15 items.
  localparam int IDX_W  = 4;

  localparam logic [SUB_W-1:0] SUB_WRITE = 4'd0;
  localparam logic [SUB_W-1:0] SUB_READ  = 4'd1;
  localparam logic [SUB_W-1:0] SUB_RMW   = 4'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_RMW_RD,
    ST_RMW_WR
  } engStateE;

  typedef struct packed {
    logic             loadPayload;
    logic             clearRdBuf;
    logic             rdItem;
    logic             wrItem;
    logic             rmwRead;
    logic             rmwWrite;
    logic [IDX_W-1:0] itemIdx;
    logic [IDX_W-1:0] itemCnt;
  } ctrlStrobeT;

endpackage

// File: rtl/batchCtrl.sv
module batchCtrl
  import regBatchPkg::*;
#(
  parameter int          MAX_ITEMS = 5,
  parameter int          SIZE_W    = 8,
  parameter logic [7:0]  CMD_CODE  = 8'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [7:0]         cmdCodeIn,
  input  logic [SUB_W-1:0]   subCmdIn,
  input  logic [SIZE_W-1:0]  sizeIn,
  output ctrlStrobeT         strobe,
  output logic               busy,
  output logic               doneOut,
  output logic               errOut
);

  engStateE         state;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] cntQ;
  logic             isWrQ;
  logic             doneQ;
  logic             errQ;

  logic [IDX_W-1:0] readN;
  logic [IDX_W-1:0] writeN;
  logic             cmdOk;
  logic             launch;

  // Size decode: item count implied by the byte count for each form.
  always_comb begin
    readN  = '0;
    writeN = '0;
    for (int n = 1; n <= MAX_ITEMS; n++) begin
      if (sizeIn == SIZE_W'(2 * n)) readN  = IDX_W'(n);
      if (sizeIn == SIZE_W'(3 * n)) writeN = IDX_W'(n);
    end
  end

  always_comb begin
    cmdOk = 1'b0;
    if (cmdCodeIn == CMD_CODE) begin
      unique case (subCmdIn)
        SUB_READ:  cmdOk = (readN != '0);
        SUB_WRITE: cmdOk = (writeN != '0);
        SUB_RMW:   cmdOk = (sizeIn == SIZE_W'(4));
        default:   cmdOk = 1'b0;
      endcase
    end
  end

  assign launch = startIn && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxQ  <= '0;
      cntQ  <= '0;
      isWrQ <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startIn) begin
            if (!cmdOk) begin
              doneQ <= 1'b1;
              errQ  <= 1'b1;
            end else if (subCmdIn == SUB_RMW) begin
              state <= ST_RMW_RD;
              idxQ  <= '0;
              cntQ  <= IDX_W'(1);
            end else begin
              state <= ST_XFER;
              idxQ  <= '0;
              cntQ  <= (subCmdIn == SUB_READ) ? readN : writeN;
              isWrQ <= (subCmdIn == SUB_WRITE);
            end
          end
        end
        ST_XFER: begin
          if (idxQ == cntQ - IDX_W'(1)) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
            errQ  <= 1'b0;
          end else begin
            idxQ <= idxQ + IDX_W'(1);
          end
        end
        ST_RMW_RD: state <= ST_RMW_WR;
        ST_RMW_WR: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
          errQ  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.loadPayload = launch && cmdOk;
    strobe.clearRdBuf  = launch && cmdOk && (subCmdIn == SUB_READ);
    strobe.rdItem      = (state == ST_XFER) && !isWrQ;
    strobe.wrItem      = (state == ST_XFER) && isWrQ;
    strobe.rmwRead     = (state == ST_RMW_RD);
    strobe.rmwWrite    = (state == ST_RMW_WR);
    strobe.itemIdx     = idxQ;
    strobe.itemCnt     = cntQ;
  end

  assign busy    = (state != ST_IDLE);
  assign doneOut = doneQ;
  assign errOut  = errQ;

endmodule

// File: rtl/batchDatapath.sv
module batchDatapath
  import regBatchPkg::*;
#(
  parameter int MAX_ITEMS = 5,
  localparam int WBUF_BYTES = (3 * MAX_ITEMS > 4) ? 3 * MAX_ITEMS : 4,
  localparam int PAY_W      = WBUF_BYTES * BYTE_W,
  localparam int RBUF_W     = MAX_ITEMS * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [PAY_W-1:0]  payloadIn,
  input  logic [BYTE_W-1:0] rfRdData,
  output logic [ADDR_W-1:0] rfAddr,
  output logic              rfRdEn,
  output logic              rfWrEn,
  output logic [BYTE_W-1:0] rfWrData,
  output logic [RBUF_W-1:0] rdBufOut
);

  localparam int SEL_W = $clog2(WBUF_BYTES);

  logic [PAY_W-1:0]  payloadQ;
  logic [BYTE_W-1:0] payByte [WBUF_BYTES];
  logic [BYTE_W-1:0] rmwOldQ;
  logic [SEL_W-1:0]  loSel;
  logic [SEL_W-1:0]  hiSel;
  logic [SEL_W-1:0]  dataSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   payloadQ <= '0;
    else if (strobe.loadPayload) payloadQ <= payloadIn;
  end

  for (genvar b = 0; b < WBUF_BYTES; b++) begin : g_pay
    assign payByte[b] = payloadQ[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    loSel   = SEL_W'(2 * strobe.itemIdx);
    hiSel   = SEL_W'(2 * strobe.itemIdx + 1);
    dataSel = SEL_W'(2 * strobe.itemCnt + strobe.itemIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rmwOldQ <= '0;
    else if (strobe.rmwRead) rmwOldQ <= rfRdData;
  end

  assign rfAddr   = {payByte[hiSel], payByte[loSel]};
  assign rfRdEn   = strobe.rdItem | strobe.rmwRead;
  assign rfWrEn   = strobe.wrItem | strobe.rmwWrite;
  assign rfWrData = strobe.rmwWrite
                  ? ((rmwOldQ & ~payByte[3]) | (payByte[2] & payByte[3]))
                  : payByte[dataSel];

  for (genvar g = 0; g < MAX_ITEMS; g++) begin : g_rdbuf
    logic [BYTE_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  slotQ <= '0;
      else if (strobe.clearRdBuf) slotQ <= '0;
      else if (strobe.rdItem && strobe.itemIdx == IDX_W'(g))
                                  slotQ <= rfRdData;
    end
    assign rdBufOut[g*BYTE_W +: BYTE_W] = slotQ;
  end

endmodule

// File: rtl/regBatchEngine.sv
module regBatchEngine
  import regBatchPkg::*;
#(
  parameter int         MAX_ITEMS = 5,
  parameter int         SIZE_W    = 8,
  parameter logic [7:0] CMD_CODE  = 8'hFF,
  localparam int WBUF_BYTES = (3 * MAX_ITEMS > 4) ? 3 * MAX_ITEMS : 4,
  localparam int PAY_W      = WBUF_BYTES * BYTE_W,
  localparam int RBUF_W     = MAX_ITEMS * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [7:0]        cmdCodeIn,
  input  logic [SUB_W-1:0]  subCmdIn,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic [PAY_W-1:0]  payloadIn,
  output logic [ADDR_W-1:0] rfAddr,
  output logic              rfRdEn,
  input  logic [BYTE_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [BYTE_W-1:0] rfWrData,
  output logic              busy,
  output logic              doneOut,
  output logic              errOut,
  output logic [RBUF_W-1:0] rdBufOut
);

  ctrlStrobeT strobe;

  batchCtrl #(
    .MAX_ITEMS(MAX_ITEMS),
    .SIZE_W   (SIZE_W),
    .CMD_CODE (CMD_CODE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .cmdCodeIn(cmdCodeIn),
    .subCmdIn (subCmdIn),
    .sizeIn   (sizeIn),
    .strobe   (strobe),
    .busy     (busy),
    .doneOut  (doneOut),
    .errOut   (errOut)
  );

  batchDatapath #(
    .MAX_ITEMS(MAX_ITEMS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .payloadIn(payloadIn),
    .rfRdData (rfRdData),
    .rfAddr   (rfAddr),
    .rfRdEn   (rfRdEn),
    .rfWrEn   (rfWrEn),
    .rfWrData (rfWrData),
    .rdBufOut (rdBufOut)
  );

endmodule

// File: rtl/regBatchChecker.sv
module regBatchChecker #(
  parameter int RBUF_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneOut,
  input logic              errOut,
  input logic              rfRdEn,
  input logic              rfWrEn,
  input logic [15:0]       rfAddr,
  input logic [RBUF_W-1:0] rdBufOut,
  input logic              rmwReadPhase
);

  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(rfRdEn && rfWrEn));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rfRdEn && !rfWrEn));

  assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busy);

  assert_err_no_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && errOut) |-> (!$past(rfRdEn) && !$past(rfWrEn)));

  assert_err_keeps_rdbuf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && errOut) |-> $stable(rdBufOut));

  assert_rmw_back_to_back_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rmwReadPhase && rfRdEn) |=> (rfWrEn && $stable(rfAddr)));

endmodule

bind regBatchEngine regBatchChecker #(.RBUF_W(RBUF_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .doneOut     (doneOut),
  .errOut      (errOut),
  .rfRdEn      (rfRdEn),
  .rfWrEn      (rfWrEn),
  .rfAddr      (rfAddr),
  .rdBufOut    (rdBufOut),
  .rmwReadPhase(strobe.rmwRead)
);

// File: tb/test_regBatchEngine.sv
module test_regBatchEngine;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [7:0]   cmdCodeIn = '0;
  logic [3:0]   subCmdIn = '0;
  logic [7:0]   sizeIn = '0;
  logic [119:0] payloadIn = '0;
  logic [15:0]  rfAddr;
  logic         rfRdEn;
  logic [7:0]   rfRdData;
  logic         rfWrEn;
  logic [7:0]   rfWrData;
  logic         busy;
  logic         doneOut;
  logic         errOut;
  logic [39:0]  rdBufOut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regBatchEngine i_regBatchEngine (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmdCodeIn(cmdCodeIn),
    .subCmdIn(subCmdIn), .sizeIn(sizeIn), .payloadIn(payloadIn),
    .rfAddr(rfAddr), .rfRdEn(rfRdEn), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrData(rfWrData), .busy(busy), .doneOut(doneOut), .errOut(errOut),
    .rdBufOut(rdBufOut)
  );

  function automatic logic [7:0] slotOf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction

  // Register file model and its independent mirror.
  logic [7:0] rfMem  [256];
  logic [7:0] refMem [256];
  assign rfRdData = rfMem[slotOf(rfAddr)];
  always @(posedge clk) if (rfWrEn) rfMem[slotOf(rfAddr)] <= rfWrData;

  // Access logs: kind 0 read, 1 write.
  bit         expKind [8];
  logic [15:0] expAddr [8];
  logic [7:0]  expData [8];
  int          expN;
  bit          logKind [8];
  logic [15:0] logAddr [8];
  logic [7:0]  logData [8];
  int          logN;
  logic [39:0] expRdBuf = '0;

  logic [15:0] tAddr [5];
  logic [7:0]  tData [5];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [119:0] buildPay(input int n, input bit withData);
    logic [119:0] p = '0;
    for (int k = 0; k < n; k++) begin
      p[(2*k)*8 +: 8]   = tAddr[k][7:0];
      p[(2*k+1)*8 +: 8] = tAddr[k][15:8];
      if (withData) p[(2*n+k)*8 +: 8] = tData[k];
    end
    return p;
  endfunction

  function automatic void seedItems(input int seed);
    for (int k = 0; k < 5; k++) begin
      tAddr[k] = 16'(seed * 16'h1357 + k * 16'h0311 + 16'h0102);
      tData[k] = 8'(seed * 29 + k * 53 + 7);
    end
  endfunction

  task automatic runCmd(input logic [7:0] code, input logic [3:0] sub,
                        input logic [7:0] size, input logic [119:0] pay,
                        input string req, input int intrudeAt);
    bit valid;
    int n;
    int lat;
    bit errSeen;
    bit gotDone;
    logic [39:0] expRd;
    logic [15:0] a;
    logic [7:0] oldV, newV;
    int mism;
    // expected behaviour from the requirements
    n = 0;
    valid = 1'b0;
    if (code == 8'hFF) begin
      if (sub == 4'd1 && size[0] == 1'b0 && size >= 2 && size <= 10) begin
        valid = 1'b1; n = int'(size) / 2;
      end else if (sub == 4'd0 && (int'(size) % 3) == 0 && size >= 3 && size <= 15) begin
        valid = 1'b1; n = int'(size) / 3;
      end else if (sub == 4'd2 && size == 8'd4) begin
        valid = 1'b1;
      end
    end
    expN = 0;
    expRd = expRdBuf;
    if (valid && sub == 4'd1) begin
      expRd = '0;
      for (int k = 0; k < n; k++) begin
        a = {pay[(2*k+1)*8 +: 8], pay[(2*k)*8 +: 8]};
        expKind[expN] = 1'b0; expAddr[expN] = a; expData[expN] = 8'h00; expN++;
        expRd[k*8 +: 8] = refMem[slotOf(a)];
      end
    end else if (valid && sub == 4'd0) begin
      for (int k = 0; k < n; k++) begin
        a = {pay[(2*k+1)*8 +: 8], pay[(2*k)*8 +: 8]};
        expKind[expN] = 1'b1; expAddr[expN] = a; expData[expN] = pay[(2*n+k)*8 +: 8]; expN++;
        refMem[slotOf(a)] = pay[(2*n+k)*8 +: 8];
      end
    end else if (valid && sub == 4'd2) begin
      a = {pay[15:8], pay[7:0]};
      oldV = refMem[slotOf(a)];
      newV = (oldV & ~pay[31:24]) | (pay[23:16] & pay[31:24]);
      expKind[0] = 1'b0; expAddr[0] = a; expData[0] = 8'h00;
      expKind[1] = 1'b1; expAddr[1] = a; expData[1] = newV;
      expN = 2;
      refMem[slotOf(a)] = newV;
    end

    @(negedge clk);
    cmdCodeIn = code; subCmdIn = sub; sizeIn = size; payloadIn = pay;
    startIn = 1'b1;
    logN = 0; lat = 0; gotDone = 1'b0; errSeen = 1'b0;
    for (int c = 1; c <= 20 && !gotDone; c++) begin
      @(negedge clk);
      if (c == 1) startIn = 1'b0;
      if (c == intrudeAt) begin
        // R9: a second start during the batch must be dropped
        cmdCodeIn = 8'hFF; subCmdIn = 4'd0; sizeIn = 8'd3;
        payloadIn = 120'h00_55_0BAD;
        startIn = 1'b1;
      end
      if (c == intrudeAt + 1) startIn = 1'b0;
      if ((rfRdEn || rfWrEn) && logN < 8) begin
        logKind[logN] = rfWrEn; logAddr[logN] = rfAddr;
        logData[logN] = rfWrEn ? rfWrData : 8'h00;
        logN++;
      end
      if (doneOut) begin gotDone = 1'b1; lat = c; errSeen = errOut; end
    end
    startIn = 1'b0;

    check(lat == expN + 1, "R8", "done latency", 64'(lat), 64'(expN + 1));
    check(errSeen == !valid, valid ? "R8" : req, "error flag", 64'(errSeen), 64'(!valid));
    check(logN == expN, req, "access count", 64'(logN), 64'(expN));
    for (int k = 0; k < expN && k < logN; k++) begin
      check(logKind[k] == expKind[k] && logAddr[k] == expAddr[k] && logData[k] == expData[k],
            req, "access kind/addr/data",
            {31'd0, logKind[k], logAddr[k], 8'd0, logData[k]},
            {31'd0, expKind[k], expAddr[k], 8'd0, expData[k]});
    end
    check(rdBufOut == expRd, valid ? "R3" : "R7", "read buffer", 64'(rdBufOut), 64'(expRd));
    expRdBuf = expRd;
    @(negedge clk);
    mism = 0;
    for (int i = 0; i < 256; i++) if (rfMem[i] !== refMem[i]) mism++;
    check(mism == 0, valid ? "R5" : "R7", "register file mismatches", 64'(mism), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [119:0] p;
    for (int i = 0; i < 256; i++) begin
      rfMem[i]  = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 0 && doneOut == 0 && errOut == 0 && rfRdEn == 0 && rfWrEn == 0,
          "R11", "control outputs in reset", {busy, doneOut, errOut, rfRdEn, rfWrEn}, 0);
    check(rdBufOut == '0, "R11", "read buffer in reset", 64'(rdBufOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && doneOut == 0 && errOut == 0, "R11", "idle after reset",
          {busy, doneOut, errOut}, 0);

    // R2/R3: reads, largest first so stale upper bytes must be cleared
    for (int s = 0; s < 4; s++)
      for (int n = 5; n >= 1; n--) begin
        seedItems(s * 5 + n);
        runCmd(8'hFF, 4'd1, 8'(2 * n), buildPay(n, 1'b0), "R2", 0);
      end
    // R4: writes followed by a read-back
    for (int s = 0; s < 4; s++)
      for (int n = 1; n <= 5; n++) begin
        seedItems(s * 11 + n);
        runCmd(8'hFF, 4'd0, 8'(3 * n), buildPay(n, 1'b1), "R4", 0);
        runCmd(8'hFF, 4'd1, 8'(2 * n), buildPay(n, 1'b0), "R3", 0);
      end
    // R5: repeated address inside one write batch, last item wins
    seedItems(3);
    tAddr[2] = tAddr[0]; tAddr[4] = tAddr[0];
    runCmd(8'hFF, 4'd0, 8'd15, buildPay(5, 1'b1), "R5", 0);
    runCmd(8'hFF, 4'd1, 8'd2, buildPay(1, 1'b0), "R5", 0);
    // R6: masked read-modify-write
    for (int m = 0; m < 6; m++) begin
      logic [7:0] mask;
      mask = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : (m == 2) ? 8'hA5 :
             (m == 3) ? 8'h0F : (m == 4) ? 8'h3C : 8'h81;
      p = '0;
      p[15:0]  = 16'(16'h2301 + m * 16'h0101);
      p[23:16] = 8'(8'h5A ^ (m * 8'h33));
      p[31:24] = mask;
      runCmd(8'hFF, 4'd2, 8'd4, p, "R6", 0);
      runCmd(8'hFF, 4'd1, 8'd2, p, "R6", 0);
    end
    // R7: byte count sweep for each accepted sub-command
    seedItems(9);
    for (int sub = 0; sub < 3; sub++)
      for (int sz = 0; sz <= 20; sz++)
        runCmd(8'hFF, 4'(sub), 8'(sz), buildPay(5, 1'b1), "R7", 0);
    // R1: wrong command code or sub-command
    runCmd(8'hFE, 4'd1, 8'd2, buildPay(1, 1'b0), "R1", 0);
    runCmd(8'h00, 4'd0, 8'd3, buildPay(1, 1'b1), "R1", 0);
    runCmd(8'h7F, 4'd2, 8'd4, buildPay(1, 1'b1), "R1", 0);
    for (int sub = 3; sub < 16; sub++)
      runCmd(8'hFF, 4'(sub), 8'd4, buildPay(2, 1'b0), "R1", 0);
    // R9: start during a running batch
    seedItems(21);
    runCmd(8'hFF, 4'd0, 8'd15, buildPay(5, 1'b1), "R9", 2);
    runCmd(8'hFF, 4'd1, 8'd10, buildPay(5, 1'b0), "R9", 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule